// File: doc/BRIEF.md
# Level-2 Interrupt Aggregation Controller

This block collects up to 32 level-sensitive interrupt sources and presents them to a parent interrupt controller on one or more upstream request lines. Each source passes through a synchronizer. A per-source enable bit gates it, and a per-output routing mask selects which sources may drive each upstream line. Sources are level-held. There is no acknowledge or clear action: a request lasts exactly as long as the source holds its input high.

Software uses a small word-addressed register port to do three things. It reads the raw synchronized source levels. It sets or clears individual enable bits. It programs the routing masks and the wake-enable mask. A build-time forward mask marks sources that are enabled out of reset. These sources stay enabled while the system sleeps. During sleep, a separate wake line reports any wake-enabled source that is routed to at least one output.

Top module: `irq_l2_aggregator`

## Requirements
- R1: After reset, the enable register (offset 0x00) reads FWD_MASK. Every routing register and the wake register read 0, and every upstream output and the wake output are 0.
- R2: A read of offset 0x04 returns the synchronized raw level of every source, whatever the enable bits are. regRvalid and regRdata are valid one cycle after the read request.
- R3: The enable register at offset 0x00 is read/write, one bit per source. A bit value of 1 unmasks the source and a bit value of 0 masks it.
- R4: upOut[k] is the OR over all sources of (status AND enable AND route[k]). It changes on the third rising edge after a source input changes: two synchronizer stages, then one output register.
- R5: Routing register k sits at offset 0x10 + 4*k, for k below NUM_OUT. No register clears a pending source: an output stays high while its source is held and falls only when the source deasserts. Writes to offset 0x04 have no effect.
- R6: A source that is set in no routing mask never asserts any upstream output or the wake output. Its wake-enable bit reads back as 0.
- R7: While sleepMode is 1, the effective enable is (enable OR FWD_MASK). Leaving sleep does not change the enable register.
- R8: The wake-enable register sits at offset 0x08. wakeOut is registered: it is 1 one edge after a cycle in which sleepMode is 1 and some used source is both high in the status and wake-enabled. wakeOut is 0 whenever sleepMode was 0.
- R9: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | NUM_SRC | Level-sensitive source inputs, asynchronous |
| sleepMode | input | 1 | System is suspended |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | NUM_SRC | Write data |
| regRdata | output | NUM_SRC | Read data, registered |
| regRvalid | output | 1 | Read data valid, one cycle after the request |
| upOut | output | NUM_OUT | Upstream interrupt lines |
| wakeOut | output | 1 | Wake request during sleep |

## Verification
The bench changes a source input at a falling edge and samples the upstream and wake outputs at the falling edge after the third rising edge. A separate check confirms that the output has not yet moved after only two rising edges. Register writes take effect at the single rising edge inside the request cycle. Read data is sampled at the falling edge after the edge that registered it. A status read therefore waits until the synchronizer has settled. A change of sleepMode or of a register acts on the outputs one edge later, because the source status is already stable at that point. The bench samples at that point.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

  localparam int MAX_OUTS    = 16;
  localparam int ROUTE_IDX_W = $clog2(MAX_OUTS);

  localparam int OFS_ENABLE     = 'h00;
  localparam int OFS_STATUS     = 'h04;
  localparam int OFS_WAKE       = 'h08;
  localparam int OFS_ROUTE_BASE = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS,
    SEL_WAKE,
    SEL_ROUTE
  } regSel_e;

  typedef struct packed {
    logic                   wrEnable;
    logic                   wrWake;
    logic                   wrRoute;
    logic                   rdStrobe;
    regSel_e                rdSel;
    logic [ROUTE_IDX_W-1:0] routeIdx;
  } regStrobe_t;

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl
  import l2irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_OUT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output logic              rdValid
);

  logic [ADDR_W-1:0] routeOfs;
  logic [ADDR_W-1:0] routeWord;
  logic              routeHit;
  regSel_e           sel;

  always_comb begin
    routeOfs  = regAddr - ADDR_W'(OFS_ROUTE_BASE);
    routeWord = routeOfs >> 2;
    routeHit  = (regAddr >= ADDR_W'(OFS_ROUTE_BASE)) &&
                (regAddr[1:0] == 2'b00) &&
                (routeWord < ADDR_W'(NUM_OUT));
  end

  always_comb begin
    if (regAddr == ADDR_W'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (regAddr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (regAddr == ADDR_W'(OFS_WAKE))   sel = SEL_WAKE;
    else if (routeHit)                       sel = SEL_ROUTE;
    else                                     sel = SEL_NONE;
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = sel;
    strobe.routeIdx = routeWord[ROUTE_IDX_W-1:0];
    if (regValid) begin
      if (regWrite) begin
        strobe.wrEnable = (sel == SEL_ENABLE);
        strobe.wrWake   = (sel == SEL_WAKE);
        strobe.wrRoute  = (sel == SEL_ROUTE);
      end else begin
        strobe.rdStrobe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.rdStrobe;
  end

endmodule

// File: rtl/l2irq_datapath.sv
module l2irq_datapath
  import l2irq_pkg::*;
#(
  parameter int               NUM_SRC     = 32,
  parameter int               NUM_OUT     = 2,
  parameter int               SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] FWD_MASK  = '0,
  parameter bit               WAKE_CAP    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               sleepMode,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_OUT-1:0] upOut,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] syncStat,
  output logic [NUM_SRC-1:0] enReg,
  output logic [NUM_SRC-1:0] usedMask
);

  logic [NUM_SRC-1:0] routeReg [NUM_OUT];
  logic [NUM_SRC-1:0] wakeReg;
  logic [NUM_SRC-1:0] enEff;

  l2irq_sync #(
    .WIDTH (NUM_SRC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(srcIn),
    .syncOut(syncStat)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enReg <= FWD_MASK;
    else if (strobe.wrEnable) enReg <= wrData;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) routeReg[k] <= '0;
      else if (strobe.wrRoute && (strobe.routeIdx == ROUTE_IDX_W'(k)))
        routeReg[k] <= wrData;
    end
  end

  always_comb begin
    usedMask = '0;
    for (int k = 0; k < NUM_OUT; k++) usedMask = usedMask | routeReg[k];
  end

  always_comb enEff = sleepMode ? (enReg | FWD_MASK) : enReg;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) upOut[k] <= 1'b0;
      else       upOut[k] <= |(syncStat & enEff & routeReg[k]);
    end
  end

  if (WAKE_CAP) begin : g_wake
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              wakeReg <= '0;
      else if (strobe.wrWake) wakeReg <= wrData;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wakeOut <= 1'b0;
      else       wakeOut <= sleepMode && (|(syncStat & wakeReg & usedMask));
    end
  end else begin : g_nowake
    assign wakeReg = '0;
    assign wakeOut = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdStrobe) begin
      case (strobe.rdSel)
        SEL_ENABLE: rdData <= enReg;
        SEL_STATUS: rdData <= syncStat;
        SEL_WAKE:   rdData <= wakeReg & usedMask;
        SEL_ROUTE:  rdData <= routeReg[strobe.routeIdx];
        default:    rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_l2_aggregator.sv
module irq_l2_aggregator
  import l2irq_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 NUM_OUT     = 2,
  parameter int                 ADDR_W      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] FWD_MASK    = '0,
  parameter bit                 WAKE_CAP    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               sleepMode,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               regRvalid,
  output logic [NUM_OUT-1:0] upOut,
  output logic               wakeOut
);

  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] syncStat;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] usedMask;

  l2irq_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_OUT(NUM_OUT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdValid (regRvalid)
  );

  l2irq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .NUM_OUT    (NUM_OUT),
    .SYNC_STAGES(SYNC_STAGES),
    .FWD_MASK   (FWD_MASK),
    .WAKE_CAP   (WAKE_CAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .sleepMode(sleepMode),
    .strobe   (strobe),
    .wrData   (regWdata),
    .rdData   (regRdata),
    .upOut    (upOut),
    .wakeOut  (wakeOut),
    .syncStat (syncStat),
    .enReg    (enReg),
    .usedMask (usedMask)
  );

endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker #(
  parameter int                 NUM_SRC  = 32,
  parameter int                 NUM_OUT  = 2,
  parameter int                 ADDR_W   = 8,
  parameter logic [NUM_SRC-1:0] FWD_MASK = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic               sleepMode,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regRvalid,
  input logic [NUM_OUT-1:0] upOut,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] syncStat,
  input logic [NUM_SRC-1:0] enReg,
  input logic [NUM_SRC-1:0] usedMask
);

  // R4: an asserted upstream line always has a pending status bit behind it
  p_status_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|upOut) |-> ($past(syncStat) != '0));

  // R3 and R7: with nothing pending, enabled and routed, every line is low
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncStat & (enReg | (sleepMode ? FWD_MASK : '0)) & usedMask) == '0)
      |-> (upOut == '0));

  // R8: wake only follows a sleeping cycle
  p_wake_sleep_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> $past(sleepMode));

  // R6: wake needs a pending source that is routed to some output
  p_wake_used_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> ($past(syncStat & usedMask) != '0));

  // R2: read data valid exactly one cycle after a read request
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> regRvalid);

  // R7: enable register changes only by a write to its offset
  p_enable_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regWrite && (regAddr == '0)) |=> $stable(enReg));

endmodule

bind irq_l2_aggregator l2irq_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_OUT (NUM_OUT),
  .ADDR_W  (ADDR_W),
  .FWD_MASK(FWD_MASK)
) u_l2irq_checker (.*);

// File: tb/test_irq_l2_aggregator.sv
`timescale 1ns/1ps
module test_irq_l2_aggregator;

  localparam int          NSRC = 32;
  localparam int          NOUT = 2;
  localparam int          AW   = 8;
  localparam logic [31:0] FWD  = 32'h0000_0100;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic            sleepMode = 1'b0;
  logic            regValid = 1'b0;
  logic            regWrite = 1'b0;
  logic [AW-1:0]   regAddr = '0;
  logic [NSRC-1:0] regWdata = '0;
  logic [NSRC-1:0] regRdata;
  logic            regRvalid;
  logic [NOUT-1:0] upOut;
  logic            wakeOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_l2_aggregator #(
    .NUM_SRC (NSRC),
    .NUM_OUT (NOUT),
    .ADDR_W  (AW),
    .FWD_MASK(FWD)
  ) i_irq_l2_aggregator (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .sleepMode(sleepMode),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .regRvalid(regRvalid),
    .upOut    (upOut),
    .wakeOut  (wakeOut)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [31:0] r0;
    logic [31:0] r1;
    logic [1:0]  expOut;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0002, 2'b01},
    '{32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0002, 2'b10},
    '{32'hF000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1000_0000, 2'b10},
    '{32'h00FF_0000, 32'h0000_FFFF, 32'h00FF_0000, 32'h00FF_0000, 2'b00},
    '{32'h8000_0001, 32'h8000_0001, 32'h8000_0000, 32'h0000_0001, 2'b11}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
    d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(8'h00, rd); check("R1 enable reset", rd, FWD);
    regRd(8'h10, rd); check("R1 route0 reset", rd, 0);
    regRd(8'h14, rd); check("R1 route1 reset", rd, 0);
    regRd(8'h08, rd); check("R1 wake reset", rd, 0);
    check("R1 outputs reset", {29'd0, wakeOut, upOut}, 0);

    // Vector table: R2, R3, R4, R5
    for (int v = 0; v < 5; v++) begin
      regWr(8'h00, VECS[v].en);
      regWr(8'h10, VECS[v].r0);
      regWr(8'h14, VECS[v].r1);
      @(negedge clk);
      srcIn = VECS[v].src;
      settle();
      check("R4 vector outputs", {30'd0, upOut}, {30'd0, VECS[v].expOut});
      regRd(8'h04, rd); check("R2 vector status", rd, VECS[v].src);
      regRd(8'h00, rd); check("R3 vector enable", rd, VECS[v].en);
      regRd(8'h14, rd); check("R5 vector route1", rd, VECS[v].r1);
    end

    // R4 latency: no change after two edges, change after the third
    regWr(8'h00, 32'h0000_0010);
    regWr(8'h10, 32'h0000_0010);
    regWr(8'h14, 32'h0);
    @(negedge clk);
    srcIn = 32'h0000_0010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 not yet after two edges", {31'd0, upOut[0]}, 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 asserted after third edge", {31'd0, upOut[0]}, 1);

    // R5 level held, no acknowledge; status write ignored
    regWr(8'h04, 32'h0);
    repeat (4) @(negedge clk);
    check("R5 held after status write", {31'd0, upOut[0]}, 1);
    regRd(8'h04, rd); check("R5 status unchanged by write", rd, 32'h0000_0010);
    srcIn = 32'h0;
    settle();
    check("R5 drops with source", {31'd0, upOut[0]}, 0);

    // R6 unused source: enabled, pending, routed nowhere
    regWr(8'h00, 32'hFFFF_FFFF);
    regWr(8'h10, 32'h0000_0008);
    regWr(8'h08, 32'h0010_0008);
    regRd(8'h08, rd); check("R6 wake bits of unused read 0", rd, 32'h0000_0008);
    @(negedge clk);
    sleepMode = 1'b1;
    srcIn = 32'h0010_0000;
    settle();
    check("R6 unused source no output", {30'd0, upOut}, 0);
    check("R6 unused source no wake", {31'd0, wakeOut}, 0);

    // R8 wake during sleep, none when awake
    srcIn = 32'h0000_0008;
    settle();
    check("R8 wake in sleep", {31'd0, wakeOut}, 1);
    sleepMode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 no wake awake", {31'd0, wakeOut}, 0);
    srcIn = 32'h0;

    // R7 forward mask forced on during sleep only
    regWr(8'h00, 32'h0);
    regWr(8'h10, FWD);
    @(negedge clk);
    srcIn = FWD;
    settle();
    check("R7 fwd masked while awake", {31'd0, upOut[0]}, 0);
    sleepMode = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 fwd enabled in sleep", {31'd0, upOut[0]}, 1);
    sleepMode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R7 fwd masked after wake", {31'd0, upOut[0]}, 0);
    regRd(8'h00, rd); check("R7 enable unchanged", rd, 0);

    // R9 unmapped offsets
    regWr(8'h40, 32'hFFFF_FFFF);
    regWr(8'h18, 32'hFFFF_FFFF);
    regRd(8'h40, rd); check("R9 unmapped read", rd, 0);
    regRd(8'h18, rd); check("R9 past last route read", rd, 0);
    regRd(8'h00, rd); check("R9 enable untouched", rd, 0);
    regRd(8'h10, rd); check("R9 route0 untouched", rd, FWD);
    check("R9 outputs quiet", {30'd0, upOut}, 0);

    finishRun();
  end

endmodule